// File: doc/BRIEF.md
# Register-Mapped NVM Lock Arbiter

This block lets up to four software agents take turns on one shared non-volatile memory port. It uses a single register that carries both requests and grants. An agent asks for the port by writing a 1 to its set strobe. It gives the port back by writing a 1 to its clear strobe. The block grants a lock to one requester. Once an agent holds the lock, it keeps it until its own request bit is cleared, even if a higher-priority agent asks in the meantime. When the lock is freed, it passes to the pending agent with the lowest index.

A second, two-bit register controls access to the neighbouring memory-interface registers. One bit enables register writes to the rest of the memory interface; the arbitration register stays writable in every case. The other bit lets the memory write command proceed even when the global write enable from the mode control logic is low. The block exposes these two decisions as level outputs, alongside a per-agent grant vector.

Top module: `nvm_lock_arb`

## Requirements
- R1: After reset, every request bit, grant bit and access-register bit is 0. Both registers read 0, `grant_o` is 0 and `reg_wr_allow_o` is 0.
- R2: A write to the arbitration register (address 0) that has bit n (n = 0..3) set makes request n read 1 in bit 12+n from the next cycle. A 0 in a set bit, and any bit outside the strobe fields, leaves the requests unchanged.
- R3: A 1 in write bit 4+n clears request n. This works no matter which agent issues the write. When one write both sets and clears the same request, the clear wins.
- R4: At most one grant bit is 1 at any time. Grant n reads in bit 8+n and also drives `grant_o[n]`.
- R5: When no lock is held, the pending request with the lowest index is granted. The grant becomes visible in the same cycle as the request that caused it.
- R6: A grant is not preempted. It stays with its owner while the owner's request remains set, even if a higher-priority request arrives.
- R7: When the owner's request is cleared, the highest-priority remaining request is granted in the cycle after the release write. If no request remains, no grant is shown.
- R8: The access register (address 1) holds access enable in bit 0 and write enable in bit 1. Both bits are read/write. All other bits read 0.
- R9: `reg_wr_allow_o` equals the access enable bit. Writes to the arbitration register never change the access register, and access-register writes never change the requests.
- R10: `nvm_wr_allow_o` is 1 when `mode_wr_en_i` is 1 or the access write enable bit is 1.
- R11: Reads of the arbitration register return 0 in bits 7:0 and 31:16. Reads of any unmapped address return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address (0 arbitration, 1 access) |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| mode_wr_en_i | input | 1 | Global write enable from mode control |
| grant_o | output | 4 | One-hot-or-zero lock owner |
| reg_wr_allow_o | output | 1 | Writes to other interface registers permitted |
| nvm_wr_allow_o | output | 1 | Memory write command permitted |

## Verification
A write takes effect at the clock edge that samples it. Requests and access bits change at that edge, and so does a grant that a new request causes or a release transfers. The gating outputs follow the access bits on that same edge, and `nvm_wr_allow_o` also follows `mode_wr_en_i` combinationally. The bench therefore drives each write on a falling edge and holds it through one rising edge. It then reads the registers and outputs at the next falling edge, half a period after the update, so every result is due exactly there.

// File: rtl/nvm_lock_pkg.sv
package nvm_lock_pkg;
  localparam int unsigned AGENTS = 4;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ARB_ADDR = 2'd0;
  localparam logic [ADDR_W-1:0] ACC_ADDR = 2'd1;

  typedef struct packed {
    logic wr_en;
    logic acc_en;
  } acc_reg_t;
endpackage

// File: rtl/nvm_lock_req_bank.sv
module nvm_lock_req_bank #(
  parameter int unsigned N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] req_o,
  output logic [N-1:0] req_nxt_o
);
  logic [N-1:0] req_q;

  // clear dominates set
  assign req_nxt_o = wr_i ? ((req_q | set_i) & ~clr_i) : req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q <= '0;
    else         req_q <= req_nxt_o;
  end

  assign req_o = req_q;

  a_r2_set_takes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> ((req_o & $past(set_i & ~clr_i)) == $past(set_i & ~clr_i)));
  a_r2_idle_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(req_o));
  a_r3_clear_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && (clr_i != '0)) |=> ((req_o & $past(clr_i)) == '0));
endmodule

// File: rtl/nvm_lock_grant.sv
module nvm_lock_grant #(
  parameter int unsigned N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  input  logic [N-1:0] req_nxt_i,
  output logic [N-1:0] gnt_o
);
  logic [N-1:0] gnt_q, gnt_d, pick;
  logic         held;

  // lowest index wins
  always_comb begin
    pick = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_nxt_i[i]) begin
        pick    = '0;
        pick[i] = 1'b1;
      end
    end
  end

  assign held  = |(gnt_q & req_nxt_i);
  assign gnt_d = held ? gnt_q : pick;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gnt_q <= '0;
    else         gnt_q <= gnt_d;
  end

  assign gnt_o = gnt_q;

  a_r4_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_q));
  a_r5_owner_requests: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_q & ~req_i) == '0);
  a_r6_no_preempt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((gnt_q & req_nxt_i) != '0) |=> (gnt_q == $past(gnt_q)));
  a_r7_no_idle_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i != '0) |-> (gnt_q != '0));
endmodule

// File: rtl/nvm_lock_acc_ctrl.sv
module nvm_lock_acc_ctrl
  import nvm_lock_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [1:0] wdata_i,
  input  logic       mode_wr_en_i,
  output acc_reg_t   acc_o,
  output logic       reg_wr_allow_o,
  output logic       nvm_wr_allow_o
);
  acc_reg_t acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   acc_q <= '0;
    else if (wr_i) acc_q <= acc_reg_t'(wdata_i);
  end

  assign acc_o          = acc_q;
  assign reg_wr_allow_o = acc_q.acc_en;
  assign nvm_wr_allow_o = mode_wr_en_i | acc_q.wr_en;

  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(acc_q));
  a_r10_override: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && wdata_i[1]) |=> nvm_wr_allow_o);
endmodule

// File: rtl/nvm_lock_arb.sv
module nvm_lock_arb
  import nvm_lock_pkg::*;
#(
  parameter int unsigned N  = AGENTS,
  parameter int unsigned DW = DATA_W,
  parameter int unsigned AW = ADDR_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic          mode_wr_en_i,
  output logic [N-1:0]  grant_o,
  output logic          reg_wr_allow_o,
  output logic          nvm_wr_allow_o
);
  localparam int unsigned SET_LSB = 0;
  localparam int unsigned CLR_LSB = N;
  localparam int unsigned GNT_LSB = 2 * N;
  localparam int unsigned REQ_LSB = 3 * N;

  logic         wr_arb, wr_acc;
  logic [N-1:0] req, req_nxt, gnt;
  acc_reg_t     acc;
  logic         unused_wdata;

  assign wr_arb       = wr_en_i && (addr_i == AW'(ARB_ADDR));
  assign wr_acc       = wr_en_i && (addr_i == AW'(ACC_ADDR));
  assign unused_wdata = ^wdata_i[DW-1:2*N];

  nvm_lock_req_bank #(.N(N)) u_req (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr_arb),
    .set_i     (wdata_i[SET_LSB +: N]),
    .clr_i     (wdata_i[CLR_LSB +: N]),
    .req_o     (req),
    .req_nxt_o (req_nxt)
  );

  nvm_lock_grant #(.N(N)) u_gnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req),
    .req_nxt_i (req_nxt),
    .gnt_o     (gnt)
  );

  nvm_lock_acc_ctrl u_acc (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .wr_i           (wr_acc),
    .wdata_i        (wdata_i[1:0]),
    .mode_wr_en_i   (mode_wr_en_i),
    .acc_o          (acc),
    .reg_wr_allow_o (reg_wr_allow_o),
    .nvm_wr_allow_o (nvm_wr_allow_o)
  );

  always_comb begin
    rdata_o = '0;
    if (addr_i == AW'(ARB_ADDR)) begin
      rdata_o[REQ_LSB +: N] = req;
      rdata_o[GNT_LSB +: N] = gnt;
    end else if (addr_i == AW'(ACC_ADDR)) begin
      rdata_o[1:0] = acc;
    end
  end

  assign grant_o = gnt;

  a_r9_acc_isolated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_arb |=> $stable(reg_wr_allow_o));
endmodule

// File: tb/sim_nvm_lock_arb.sv
`timescale 1ns/1ps
module sim_nvm_lock_arb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        mode_wr_en = 1'b0;
  logic [3:0]  grant;
  logic        reg_allow, nvm_allow;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  nvm_lock_arb u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .mode_wr_en_i(mode_wr_en),
    .grant_o(grant), .reg_wr_allow_o(reg_allow), .nvm_wr_allow_o(nvm_allow)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    addr = a;
    #0.5;
    d = rdata;
  endtask

  // check arbitration state: register bits and grant port
  task automatic chk_arb(input string tag, input logic [3:0] r, input logic [3:0] g);
    logic [31:0] d;
    rd(2'd0, d);
    chk({tag, " arb"}, d, {16'h0, r, g, 8'h00});
    chk({tag, " grant_o"}, {28'h0, grant}, {28'h0, g});
    chk("R4 onehot", {31'h0, ($countones(grant) <= 1)}, 32'h1);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk_arb("R1 reset", 4'h0, 4'h0);
    rd(2'd1, d);
    chk("R1 acc reset", d, 32'h0);
    chk("R1 reg_wr_allow", {31'h0, reg_allow}, 32'h0);
    chk("R1 nvm_wr_allow", {31'h0, nvm_allow}, 32'h0);
  endtask

  task automatic t_lock_sequence;
    wr(2'd0, 32'h0000_0004);
    chk_arb("R2 R5 set agent2", 4'b0100, 4'b0100);
    wr(2'd0, 32'h0000_0000);
    chk_arb("R2 zero write", 4'b0100, 4'b0100);
    wr(2'd0, 32'h0000_000A);
    chk_arb("R6 no preempt", 4'b1110, 4'b0100);
    wr(2'd0, 32'h0000_0040);
    chk_arb("R7 release to 1", 4'b1010, 4'b0010);
    wr(2'd0, 32'h0000_0020);
    chk_arb("R7 release to 3", 4'b1000, 4'b1000);
    wr(2'd0, 32'h0000_0080);
    chk_arb("R7 none pending", 4'b0000, 4'b0000);
  endtask

  task automatic t_clear_rules;
    wr(2'd0, 32'h0000_0022);
    chk_arb("R3 clear wins", 4'b0000, 4'b0000);
    wr(2'd0, 32'h0000_0003);
    chk_arb("R5 lowest index", 4'b0011, 4'b0001);
    wr(2'd0, 32'h0000_0010);
    chk_arb("R3 foreign release", 4'b0010, 4'b0010);
    wr(2'd0, 32'h0000_00F0);
    chk_arb("R3 clear all", 4'b0000, 4'b0000);
  endtask

  task automatic t_read_mask;
    logic [31:0] d;
    wr(2'd0, 32'hFFFF_FF00);
    chk_arb("R2 R11 upper bits ignored", 4'b0000, 4'b0000);
    wr(2'd0, 32'h0000_0008);
    rd(2'd0, d);
    chk("R11 arb read mask", d, 32'h0000_8800);
    rd(2'd2, d);
    chk("R11 unmapped 2", d, 32'h0);
    rd(2'd3, d);
    chk("R11 unmapped 3", d, 32'h0);
    wr(2'd0, 32'h0000_0080);
  endtask

  task automatic t_access;
    logic [31:0] d;
    wr(2'd1, 32'h0000_0001);
    rd(2'd1, d);
    chk("R8 acc en", d, 32'h1);
    chk("R9 reg allow on", {31'h0, reg_allow}, 32'h1);
    chk("R10 nvm off", {31'h0, nvm_allow}, 32'h0);
    chk_arb("R9 acc write no req", 4'b0000, 4'b0000);
    wr(2'd1, 32'h0000_0003);
    chk("R10 override", {31'h0, nvm_allow}, 32'h1);
    wr(2'd0, 32'h0000_0001);
    rd(2'd1, d);
    chk("R9 arb write keeps acc", d, 32'h3);
    wr(2'd1, 32'h0000_0002);
    chk("R9 reg allow off", {31'h0, reg_allow}, 32'h0);
    chk("R10 wr en alone", {31'h0, nvm_allow}, 32'h1);
    wr(2'd1, 32'hFFFF_FFFC);
    rd(2'd1, d);
    chk("R8 upper bits read 0", d, 32'h0);
    chk("R10 both off", {31'h0, nvm_allow}, 32'h0);
    mode_wr_en = 1'b1;
    #0.5;
    chk("R10 mode enable", {31'h0, nvm_allow}, 32'h1);
    mode_wr_en = 1'b0;
    chk_arb("R9 acc writes keep req", 4'b0001, 4'b0001);
    wr(2'd0, 32'h0000_0010);
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_lock_sequence();
    t_clear_rules();
    t_read_mask();
    t_access();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule